// File: doc/BRIEF.md
# Filtered Reset and Power Supervisor

This block produces the single active-high reset that holds the processor core. Three things can raise it: the external reset pin, which is active low; the power-good input; and two digital monitor flags, one for clock overfrequency and one for supply undervoltage. Every timing rule is counted in master-clock periods. The block groups these periods into machine cycles of `CLKS_PER_MC` clocks each.

The external pin first passes through a two-flop synchronizer. A filter counter then qualifies it, so that a brief dip on the line cannot reset the core. After power comes up, reset stays high for a fixed number of machine cycles. While either monitor flag is raised, reset is held. The output is the OR of the power-on, pin and monitor sources. It falls only when every source has released.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_good` is low, `cpu_rst` is high at once, with no clock edge needed.
- R2: With the pin high and both flags low, `cpu_rst` stays high through the first 17 rising edges after `pwr_good` rises. It is low after the 18th edge. That is three machine cycles of 6 clocks each.
- R3: When the pin is sampled low at the first 12 consecutive rising edges, `cpu_rst` is still low after the 13th edge and high after the 14th. The extra two edges are the two synchronizer stages.
- R4: A low run of 11 sampled edges or fewer produces no reset. A single high sample restarts the count, so two 11-edge lows separated by one high sample produce no reset.
- R5: Once the filter has qualified, `cpu_rst` stays high for as long as the pin is low. After the pin returns high it is still high after the second rising edge and low after the third.
- R6: When `over_freq` or `under_volt` is high at a rising edge, `cpu_rst` is high after that edge. It falls after the first edge at which both flags are low, provided no other source is active.
- R7: `cpu_rst` is the OR of all sources. Releasing one source while another is still active leaves `cpu_rst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| pwr_good | input | 1 | Low while power is absent; rising edge starts the power-on stretch |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| over_freq | input | 1 | Clock overfrequency flag, active high, synchronous |
| under_volt | input | 1 | Supply undervoltage flag, active high, synchronous |
| cpu_rst | output | 1 | Combined active-high core reset |

## Verification
The embedded assertions check, on every cycle, four properties:
- a raised monitor flag forces reset on the next edge;
- the pin path never asserts unless the synchronized pin was low;
- the pin path releases once the synchronized level is high;
- the power-on stretch holds the output and ends only at its final count.

The exact edge counts can only be shown by the bench's scenarios. These are the 14-edge assertion point of the pin filter, the restart on a single high sample, the three-edge release latency, and the OR behaviour when sources overlap.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int CLKS_PER_MC = 6,
  parameter int PIN_MC      = 2,
  parameter int POR_MC      = 3
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic rst_pin_n,
  input  logic over_freq,
  input  logic under_volt,
  output logic cpu_rst
);
  localparam int PIN_CLKS = CLKS_PER_MC * PIN_MC;
  localparam int POR_CLKS = CLKS_PER_MC * POR_MC;
  localparam int PW = $clog2(PIN_CLKS);
  localparam int QW = $clog2(POR_CLKS + 1);
  localparam logic [PW-1:0] PIN_TOP = PW'(PIN_CLKS - 1);
  localparam logic [QW-1:0] POR_TOP = QW'(POR_CLKS - 1);
  localparam logic [QW-1:0] POR_END = QW'(POR_CLKS);

  logic [1:0]    sync;
  logic [PW-1:0] pin_cnt;
  logic          pin_rst;
  logic [QW-1:0] por_cnt;
  logic          por_rst;
  logic          mon_rst;
  logic          pin_s;

  assign pin_s = sync[1];

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      sync    <= 2'b11;
      pin_cnt <= '0;
      pin_rst <= 1'b0;
    end else begin
      sync <= {sync[0], rst_pin_n};
      if (pin_s)                pin_cnt <= '0;
      else if (pin_cnt != PIN_TOP) pin_cnt <= pin_cnt + PW'(1);
      pin_rst <= !pin_s && (pin_cnt == PIN_TOP);
    end
  end

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      por_cnt <= '0;
      por_rst <= 1'b1;
    end else if (por_rst) begin
      por_cnt <= por_cnt + QW'(1);
      if (por_cnt == POR_TOP) por_rst <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) mon_rst <= 1'b0;
    else           mon_rst <= over_freq | under_volt;
  end

  assign cpu_rst = por_rst | pin_rst | mon_rst;

  assert_mon_forces_R6: assert property (@(posedge clk) disable iff (!pwr_good)
    (over_freq || under_volt) |=> cpu_rst);

  assert_pin_needs_low_R4: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(pin_rst) |-> $past(!pin_s));

  assert_pin_release_R5: assert property (@(posedge clk) disable iff (!pwr_good)
    pin_s |=> !pin_rst);

  assert_por_holds_R2: assert property (@(posedge clk) disable iff (!pwr_good)
    (por_cnt < POR_END) |-> cpu_rst);

  assert_por_full_len_R2: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(por_rst) |-> (por_cnt == POR_END));
endmodule

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
  logic clk = 1'b0;
  logic pwr_good = 1'b0;
  logic rst_pin_n = 1'b1;
  logic over_freq = 1'b0;
  logic under_volt = 1'b0;
  logic cpu_rst;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  rst_supervisor u_dut (
    .clk(clk), .pwr_good(pwr_good), .rst_pin_n(rst_pin_n),
    .over_freq(over_freq), .under_volt(under_volt), .cpu_rst(cpu_rst)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: cpu_rst=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_power_on();
    @(negedge clk);
    step(3);
    chk("R1 held while power low", cpu_rst, 1'b1);
    pwr_good = 1'b1;
    step(17);
    chk("R2 still high after 17 edges", cpu_rst, 1'b1);
    step(1);
    chk("R2 low after 18 edges", cpu_rst, 1'b0);
  endtask

  task automatic t_pin_full();
    rst_pin_n = 1'b0;
    step(13);
    chk("R3 not yet after 13 edges", cpu_rst, 1'b0);
    step(1);
    chk("R3 asserted after 14 edges", cpu_rst, 1'b1);
    step(30);
    chk("R5 held while pin low", cpu_rst, 1'b1);
    rst_pin_n = 1'b1;
    step(2);
    chk("R5 still high 2 edges after release", cpu_rst, 1'b1);
    step(1);
    chk("R5 low 3 edges after release", cpu_rst, 1'b0);
    step(5);
  endtask

  task automatic t_pin_short();
    logic seen = 1'b0;
    rst_pin_n = 1'b0;
    for (int i = 0; i < 11; i++) begin step(1); seen |= cpu_rst; end
    rst_pin_n = 1'b1;
    for (int i = 0; i < 20; i++) begin step(1); seen |= cpu_rst; end
    chk("R4 11-edge low ignored", seen, 1'b0);
  endtask

  task automatic t_pin_restart();
    logic seen = 1'b0;
    rst_pin_n = 1'b0;
    for (int i = 0; i < 11; i++) begin step(1); seen |= cpu_rst; end
    rst_pin_n = 1'b1;
    step(1); seen |= cpu_rst;
    rst_pin_n = 1'b0;
    for (int i = 0; i < 11; i++) begin step(1); seen |= cpu_rst; end
    rst_pin_n = 1'b1;
    for (int i = 0; i < 20; i++) begin step(1); seen |= cpu_rst; end
    chk("R4 one high sample restarts filter", seen, 1'b0);
  endtask

  task automatic t_monitor();
    over_freq = 1'b1;
    step(1);
    chk("R6 overfrequency asserts", cpu_rst, 1'b1);
    step(4);
    over_freq = 1'b0;
    step(1);
    chk("R6 overfrequency released", cpu_rst, 1'b0);
    under_volt = 1'b1;
    step(1);
    chk("R6 undervoltage asserts", cpu_rst, 1'b1);
    over_freq = 1'b1;
    step(2);
    under_volt = 1'b0;
    step(1);
    chk("R6 held while other flag high", cpu_rst, 1'b1);
    over_freq = 1'b0;
    step(1);
    chk("R6 both flags low releases", cpu_rst, 1'b0);
  endtask

  task automatic t_overlap();
    rst_pin_n = 1'b0;
    under_volt = 1'b1;
    step(20);
    chk("R7 both sources active", cpu_rst, 1'b1);
    under_volt = 1'b0;
    step(3);
    chk("R7 pin source keeps reset", cpu_rst, 1'b1);
    rst_pin_n = 1'b1;
    step(3);
    chk("R7 all released", cpu_rst, 1'b0);
    pwr_good = 1'b0;
    #1;
    chk("R1 power loss asserts immediately", cpu_rst, 1'b1);
    @(negedge clk);
    pwr_good = 1'b1;
    step(18);
    chk("R2 stretch repeats after power loss", cpu_rst, 1'b0);
  endtask

  initial begin
    t_power_on();
    t_pin_full();
    t_pin_short();
    t_pin_restart();
    t_monitor();
    t_overlap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule